// File: doc/BRIEF.md
# Fuse Array Read Controller

This block lets a host processor fetch words from a one-time-programmable fuse array through three memory-mapped registers. A control register holds the word address, a set strobe for that address, auto-read enable and start bits, a read-busy status bit and a power-down bit. A data register returns the fetched word, and a configuration register carries a descrambling enable. Some write-side fields are kept in the control register for software compatibility, but they have no effect.

A host read follows a fixed sequence. The host clears power-down and sets auto-read enable. It writes the address and raises the set bit, then lowers it again. It raises the start bit, polls until read-busy drops, and then reads the data register. The fuse array is a behavioural ROM holding 512 bytes, built as 512 one-byte words or 128 four-byte words. It answers after a fixed, parameterised number of clocks, which is far shorter than any host polling timeout.

Top module: `fuse_rd_ctrl`

## Requirements
- R1: After reset, the control register (offset 0x04) reads 0x0800_0000 (power-down bit 27 set). The data register (offset 0x08) and the configuration register (offset 0x10) read 0.
- R2: A write to any offset other than 0x04 and 0x10 changes no register. A read from any offset other than 0x04, 0x08 and 0x10 returns 0. `bus_rdata` is combinational on `bus_addr`.
- R3: The control register stores bits [10:0] (address field), 11 (address set), 12 and 13 (write enable and start, stored only), [23:16] (write byte, stored only), 24 (read enable), 25 (read start) and 27 (power-down). Bit 26 reads the read-busy flag. Bit 14 (write busy), bit 15 and bits [31:28] always read 0, so writing all ones while powered down reads back 0x0BFF_3FFF.
- R4: The configuration register stores only bit 10 (descramble enable). All its other bits read 0.
- R5: The fetch address is loaded from bits [10:0] only by a control write whose bit 11 is 1 while the stored bit 11 is 0. Writing the address field without such a rising set bit leaves the fetch address unchanged.
- R6: A read launches on a control write that meets all of these conditions: bit 25 is 1, the stored bit 25 is 0, the written bit 24 is 1, the written bit 27 is 0, and no read is in progress. Read-busy then reads 1 in the very next cycle.
- R7: Read-busy stays 1 for exactly LATENCY cycles. It clears on the same clock edge that loads the fetched word into the data register.
- R8: Fuse byte i holds (i*7 + 0x5A) mod 256. With WORD_BYTES=4, word w is bytes 4w..4w+3, with byte 4w in bits [7:0]. With WORD_BYTES=1, word w is byte w, zero-extended.
- R9: A fetch address at or beyond the array depth (512/WORD_BYTES words) returns all zeros.
- R10: A start strobe written while a read is in progress is ignored. The current read keeps its address and length, and no second read follows.
- R11: No read launches when power-down would be 1 or read enable would be 0 after the write.
- R12: The data register keeps its value until the next read completes. Host writes to offset 0x08 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | BUS_AW | Register byte offset for reads and writes |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational on bus_addr |

## Verification
The assertions check the following on every cycle:
- the busy flag rises in the cycle after a launch;
- busy can only rise from a qualifying control write, with enable set and power-down clear;
- busy never lasts longer than LATENCY cycles and falls only with the array's completion;
- no launch occurs while busy;
- the data register never changes outside a completion;
- write-busy reads 0.

Only the bench scenarios can show the following:
- the fetched word values for each address, including the out-of-range zeros;
- that an unstrobed address write is not used;
- that register storage masks and undefined offsets behave as specified;
- the exact busy length, measured from the host's side.

// File: rtl/fuse_rd_pkg.sv
package fuse_rd_pkg;
   // Register byte offsets
   localparam int OFS_CTRL = 'h04;
   localparam int OFS_DATA = 'h08;
   localparam int OFS_CFG  = 'h10;

   // Control register bit positions
   localparam int BIT_PWRDN  = 27;
   localparam int BIT_RBUSY  = 26;
   localparam int BIT_RSTART = 25;
   localparam int BIT_RENA   = 24;
   localparam int BIT_ASET   = 11;
   localparam int FADDR_W    = 11;

   localparam logic [31:0] CTRL_KEEP  = 32'h0BFF_3FFF;
   localparam logic [31:0] CTRL_RESET = 32'h0800_0000;
   localparam logic [31:0] CFG_KEEP   = 32'h0000_0400;

   localparam int ARRAY_BYTES = 512;

   // Behavioural content of one fuse byte
   function automatic logic [7:0] fuse_byte(input logic [31:0] idx);
      logic [31:0] t;
      t = idx * 32'd7 + 32'd90;
      return t[7:0];
   endfunction
endpackage

// File: rtl/fuse_rd_array.sv
module fuse_rd_array
   import fuse_rd_pkg::*;
#(
   parameter int WORD_BYTES = 4,
   parameter int LATENCY    = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               launch,
   input  logic [FADDR_W-1:0] addr,
   output logic               done,
   output logic [31:0]        word
);
   localparam int DEPTH = ARRAY_BYTES / WORD_BYTES;
   localparam int CW    = $clog2(LATENCY + 1);

   logic [FADDR_W-1:0] addr_q;
   logic [CW-1:0]      cnt_q;
   logic [31:0]        base_idx;
   logic               in_range;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         cnt_q  <= '0;
      end else if (launch) begin
         addr_q <= addr;
         cnt_q  <= CW'(LATENCY);
      end else if (cnt_q != '0) begin
         cnt_q  <= cnt_q - CW'(1);
      end
   end

   assign done     = (cnt_q == CW'(1));
   assign base_idx = 32'(addr_q) * 32'(WORD_BYTES);
   assign in_range = 32'(addr_q) < 32'(DEPTH);

   for (genvar k = 0; k < 4; k++) begin : g_lane
      if (k < WORD_BYTES) begin : g_used
         assign word[8*k +: 8] = in_range ? fuse_byte(base_idx + 32'(k)) : 8'h00;
      end else begin : g_pad
         assign word[8*k +: 8] = 8'h00;
      end
   end
endmodule

// File: rtl/fuse_rd_regs.sv
module fuse_rd_regs
   import fuse_rd_pkg::*;
#(
   parameter int BUS_AW = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_we,
   input  logic [BUS_AW-1:0]  bus_addr,
   input  logic [31:0]        bus_wdata,
   output logic [31:0]        bus_rdata,
   input  logic               rom_done,
   input  logic [31:0]        rom_word,
   output logic               launch,
   output logic [FADDR_W-1:0] fetch_addr,
   output logic               busy,
   output logic [31:0]        data_word
);
   logic [31:0] ctrl_q;
   logic [31:0] cfg_q;
   logic [31:0] ctrl_next;
   logic        wr_ctrl;
   logic        wr_cfg;
   logic        aset_rise;

   assign wr_ctrl   = bus_we && (bus_addr == BUS_AW'(OFS_CTRL));
   assign wr_cfg    = bus_we && (bus_addr == BUS_AW'(OFS_CFG));
   assign ctrl_next = bus_wdata & CTRL_KEEP;

   assign launch = wr_ctrl && ctrl_next[BIT_RSTART] && !ctrl_q[BIT_RSTART]
                   && ctrl_next[BIT_RENA] && !ctrl_next[BIT_PWRDN] && !busy;
   assign aset_rise = wr_ctrl && ctrl_next[BIT_ASET] && !ctrl_q[BIT_ASET];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q     <= CTRL_RESET;
         cfg_q      <= '0;
         fetch_addr <= '0;
         busy       <= 1'b0;
         data_word  <= '0;
      end else begin
         if (wr_ctrl)   ctrl_q     <= ctrl_next;
         if (wr_cfg)    cfg_q      <= bus_wdata & CFG_KEEP;
         if (aset_rise) fetch_addr <= ctrl_next[FADDR_W-1:0];
         if (launch)        busy <= 1'b1;
         else if (rom_done) busy <= 1'b0;
         if (rom_done)  data_word  <= rom_word;
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == BUS_AW'(OFS_CTRL)) begin
         bus_rdata = ctrl_q;
         bus_rdata[BIT_RBUSY] = busy;
      end else if (bus_addr == BUS_AW'(OFS_DATA)) begin
         bus_rdata = data_word;
      end else if (bus_addr == BUS_AW'(OFS_CFG)) begin
         bus_rdata = cfg_q;
      end
   end
endmodule

// File: rtl/fuse_rd_ctrl.sv
module fuse_rd_ctrl
   import fuse_rd_pkg::*;
#(
   parameter int WORD_BYTES = 4,
   parameter int LATENCY    = 8,
   parameter int BUS_AW     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [BUS_AW-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata
);
   if (!(WORD_BYTES == 1 || WORD_BYTES == 4)) begin : g_bad_width
      $error("fuse_rd_ctrl: WORD_BYTES must be 1 or 4");
   end
   if (LATENCY < 1 || LATENCY > 1000) begin : g_bad_latency
      $error("fuse_rd_ctrl: LATENCY must be within 1..1000");
   end
   if (BUS_AW < 5) begin : g_bad_aw
      $error("fuse_rd_ctrl: BUS_AW must reach offset 0x10");
   end

   logic               launch;
   logic [FADDR_W-1:0] fetch_addr;
   logic               rd_busy;
   logic               rom_done;
   logic [31:0]        rom_word;
   logic [31:0]        data_word;

   fuse_rd_regs #(.BUS_AW(BUS_AW)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_we     (bus_we),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .rom_done   (rom_done),
      .rom_word   (rom_word),
      .launch     (launch),
      .fetch_addr (fetch_addr),
      .busy       (rd_busy),
      .data_word  (data_word)
   );

   fuse_rd_array #(.WORD_BYTES(WORD_BYTES), .LATENCY(LATENCY)) u_array (
      .clk    (clk),
      .rst_n  (rst_n),
      .launch (launch),
      .addr   (fetch_addr),
      .done   (rom_done),
      .word   (rom_word)
   );
endmodule

// File: rtl/fuse_rd_ctrl_chk.sv
module fuse_rd_ctrl_chk #(
   parameter int LATENCY = 8,
   parameter int BUS_AW  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_we,
   input logic [BUS_AW-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic [31:0]       bus_rdata,
   input logic              launch,
   input logic              busy,
   input logic              done,
   input logic [31:0]       data_word
);
   int busy_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     busy_len <= 0;
      else if (!busy) busy_len <= 0;
      else            busy_len <= busy_len + 1;
   end

   a_r6_busy_next: assert property (@(posedge clk) disable iff (!rst_n)
      launch |=> busy);

   a_r11_start_gated: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(bus_we && bus_addr == BUS_AW'('h04)
                            && bus_wdata[24] && !bus_wdata[27]));

   a_r7_busy_bound: assert property (@(posedge clk) disable iff (!rst_n)
      busy_len <= LATENCY);

   a_r7_clear_on_done: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(done));

   a_r10_no_relaunch: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !launch);

   a_r12_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !done |=> $stable(data_word));

   a_r3_wbusy_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == BUS_AW'('h04)) |-> !bus_rdata[14]);
endmodule

bind fuse_rd_ctrl fuse_rd_ctrl_chk #(.LATENCY(LATENCY), .BUS_AW(BUS_AW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .launch    (launch),
   .busy      (rd_busy),
   .done      (rom_done),
   .data_word (data_word)
);

// File: tb/fuse_rd_ctrl_tb.sv
`timescale 1ns/1ps
module fuse_rd_ctrl_tb_top;
   localparam int WB  = 4;
   localparam int LAT = 8;
   localparam logic [31:0] ENA   = 32'h0100_0000;
   localparam logic [31:0] START = 32'h0200_0000;
   localparam logic [31:0] ASET  = 32'h0000_0800;
   localparam logic [31:0] PWDN  = 32'h0800_0000;

   logic        clk = 0;
   logic        rst_n = 0;
   logic        bus_we = 0;
   logic [7:0]  bus_addr = 8'h04;
   logic [31:0] bus_wdata = 0;
   logic [31:0] bus_rdata;

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 0;
   string cur_req = "R1";

   always #2.5 clk = ~clk;

   fuse_rd_ctrl #(.WORD_BYTES(WB), .LATENCY(LAT), .BUS_AW(8)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

   // ---------------- reference model ----------------
   function automatic logic [7:0] ref_byte(int i);
      return 8'((i * 7 + 90) % 256);
   endfunction

   function automatic logic [31:0] ref_word(int w);
      logic [31:0] v;
      v = 0;
      if (w >= 512 / WB) return 0;
      for (int k = 0; k < WB; k++) v[8*k +: 8] = ref_byte(w * WB + k);
      return v;
   endfunction

   logic [31:0] m_ctrl, m_cfg, m_data;
   logic        m_busy;
   int          m_cnt, m_faddr, m_raddr;

   function automatic logic [31:0] m_read(logic [7:0] a);
      case (a)
         8'h04:   return m_ctrl | (32'(m_busy) << 26);
         8'h08:   return m_data;
         8'h10:   return m_cfg;
         default: return 0;
      endcase
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %08h expected %08h", req, act, exp);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ctrl = 32'h0800_0000; m_cfg = 0; m_data = 0;
         m_busy = 0; m_cnt = 0; m_faddr = 0; m_raddr = 0;
      end else begin
         logic wc, go;
         wc = bus_we && bus_addr == 8'h04;
         go = wc && bus_wdata[25] && !m_ctrl[25] && bus_wdata[24]
              && !bus_wdata[27] && !m_busy;
         if (m_busy && m_cnt == 1) begin
            m_data = ref_word(m_raddr); m_busy = 0; m_cnt = 0;
         end else if (m_busy) begin
            m_cnt--;
         end
         if (go) begin
            m_busy = 1; m_cnt = LAT; m_raddr = m_faddr;
         end
         if (wc && bus_wdata[11] && !m_ctrl[11]) m_faddr = int'(bus_wdata[10:0]);
         if (wc) m_ctrl = bus_wdata & 32'h0BFF_3FFF;
         if (bus_we && bus_addr == 8'h10) m_cfg = bus_wdata & 32'h0000_0400;
      end
      #1;
      if (rst_n && !finished) chk({cur_req, " per-cycle"}, bus_rdata, m_read(bus_addr));
   end

   // ---------------- stimulus helpers ----------------
   task automatic wr(logic [7:0] a, logic [31:0] d, output logic [31:0] after);
      @(negedge clk);
      bus_we = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 0; bus_addr = 8'h04; bus_wdata = 0;
      #1 after = bus_rdata;
   endtask

   task automatic peek(logic [7:0] a, output logic [31:0] v);
      @(negedge clk);
      bus_we = 0; bus_addr = a;
      #1 v = bus_rdata;
   endtask

   // Launch from the current fetch address; report busy length and data
   task automatic run_read(output int cycles, output logic [31:0] data, output bit first_busy);
      logic [31:0] v;
      wr(8'h04, ENA | START, v);
      first_busy = v[26];
      cycles = v[26] ? 1 : 0;
      if (v[26]) begin
         forever begin
            peek(8'h04, v);
            if (v[26]) cycles++;
            else break;
         end
      end
      wr(8'h04, ENA, v);
      peek(8'h08, data);
   endtask

   task automatic set_addr(int a);
      logic [31:0] v;
      wr(8'h04, ENA | 32'(a), v);
      wr(8'h04, ENA | ASET | 32'(a), v);
      wr(8'h04, ENA | 32'(a), v);
   endtask

   initial begin
      repeat (2000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] v, d;
      int cyc;
      bit fb;
      repeat (5) @(negedge clk);
      rst_n = 1;

      cur_req = "R1";
      peek(8'h04, v); chk("R1 ctrl reset", v, 32'h0800_0000);
      peek(8'h08, v); chk("R1 data reset", v, 0);
      peek(8'h10, v); chk("R1 cfg reset", v, 0);

      cur_req = "R2";
      wr(8'h0C, 32'hFFFF_FFFF, v);
      wr(8'h00, 32'hFFFF_FFFF, v);
      wr(8'h14, 32'hFFFF_FFFF, v);
      chk("R2 ctrl untouched", v, 32'h0800_0000);
      peek(8'h0C, v); chk("R2 undefined read", v, 0);
      peek(8'h10, v); chk("R2 cfg untouched", v, 0);

      cur_req = "R4";
      wr(8'h10, 32'hFFFF_FFFF, v);
      peek(8'h10, v); chk("R4 cfg keeps bit 10", v, 32'h0000_0400);
      wr(8'h10, 0, v);

      cur_req = "R3";
      wr(8'h04, 32'hFFFF_FFFF, v); chk("R3 ctrl mask, no launch when powered down", v, 32'h0BFF_3FFF);
      wr(8'h04, 0, v);             chk("R3 ctrl cleared", v, 0);

      cur_req = "R8";
      set_addr(0);
      run_read(cyc, d, fb);
      chk("R6 busy on first read", 32'(fb), 1);
      chk("R7 busy length", 32'(cyc), LAT);
      chk("R8 word 0", d, ref_word(0));
      set_addr(1);   run_read(cyc, d, fb); chk("R8 word 1", d, ref_word(1));
      set_addr(127); run_read(cyc, d, fb); chk("R8 word 127", d, ref_word(127));
      chk("R7 busy length last word", 32'(cyc), LAT);

      cur_req = "R9";
      set_addr(128);    run_read(cyc, d, fb); chk("R9 first beyond depth", d, 0);
      set_addr(11'h7FF); run_read(cyc, d, fb); chk("R9 top address", d, 0);

      cur_req = "R5";
      set_addr(3);
      wr(8'h04, ENA | 32'd9, v);
      run_read(cyc, d, fb); chk("R5 unstrobed address ignored", d, ref_word(3));

      cur_req = "R10";
      set_addr(5);
      wr(8'h04, ENA | START, v);
      chk("R10 busy after launch", 32'(v[26]), 1);
      wr(8'h04, ENA, v);
      wr(8'h04, ENA | START, v);
      chk("R10 still busy", 32'(v[26]), 1);
      set_addr(6);
      repeat (LAT + 4) peek(8'h04, v);
      chk("R10 no second read", 32'(v[26]), 0);
      peek(8'h08, d); chk("R10 original address kept", d, ref_word(5));

      cur_req = "R11";
      wr(8'h04, 0, v);
      wr(8'h04, START, v);        chk("R11 no launch without enable", 32'(v[26]), 0);
      wr(8'h04, 0, v);
      wr(8'h04, PWDN | ENA | START, v); chk("R11 no launch when powered down", 32'(v[26]), 0);
      wr(8'h04, 0, v);
      repeat (LAT + 2) peek(8'h04, v);
      peek(8'h08, d); chk("R11 data unchanged", d, ref_word(5));

      cur_req = "R12";
      wr(8'h08, 32'h1234_5678, v);
      peek(8'h08, d); chk("R12 data write ignored", d, ref_word(5));

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule